// File: doc/BRIEF.md
# Real-time clock register file with interrupt control

This block sits between a simple processor-side register bus and a seconds-counting timekeeping core. It decodes word-aligned 32-bit reads and writes at fixed offsets. It forwards set-time, calibration and alarm writes to the core as one-cycle strobes with their data. It returns the core's readback values: pending set-time, calibration, current seconds, sub-second tick and alarm.

It also owns the interrupt logic. Two event pulses from the core, the seconds tick and the alarm match, are caught in sticky status bits. Software clears those bits by writing ones. Each interrupt is switched on and off through dedicated write-one enable and disable offsets, and its current state can be read from a read-only mask offset. Two interrupt lines leave the block, one per event. A control register holds the oscillator enable and the battery switch-over enable, and drives both as outputs.

A read returns its data on `bus_rdata_o` one cycle after the read request, and the value stays there until the next read. Forwarded write strobes appear one cycle after the bus write.

Top module: `tk_rtc_regs`

## Requirements
- R1: After reset, the interrupt status, the interrupt mask, both control bits, both interrupt outputs, all forward strobes and `bus_rdata_o` are zero.
- R2: A write to offset 0x00 (set time), 0x08 (calibration) or 0x18 (alarm) raises only the matching strobe for exactly one cycle, in the cycle after the write. The strobe carries the written data; the calibration data is the low 21 bits of the write.
- R3: The cycle after a read, `bus_rdata_o` holds the core value for that offset, zero-extended to 32 bits. The offsets are 0x04 (pending set time), 0x0C (calibration, 21 bits), 0x10 (current seconds), 0x14 (tick, 16 bits) and 0x18 (alarm).
- R4: An event pulse sets its status bit whether or not the interrupt is enabled. Bit 0 is the seconds event and bit 1 is the alarm event, and the status reads at offset 0x20 in bits [1:0].
- R5: Writing to offset 0x20 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When an event pulse and a write-one clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: Writing ones to offset 0x28 enables the matching interrupts and writing ones to 0x2C disables them; zero bits in either write leave the mask unchanged. The mask reads at 0x24 in bits [1:0].
- R8: `irq_sec_o` is high exactly when status bit 0 and mask bit 0 are both set, and `irq_alarm_o` is high exactly when status bit 1 and mask bit 1 are both set.
- R9: Offset 0x40 is the control register. Bit 31 is the battery switch-over enable and drives `batt_en_o`; bit 24 is the oscillator enable and drives `osc_en_o`. All other bits read as zero.
- R10: A read of an unmapped, write-only or non-word-aligned offset returns zero. A write to a read-only offset (0x04, 0x0C, 0x10, 0x14, 0x24) changes no state and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Bus request in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| core_settime_rd_i | input | 32 | Pending set-time value from the core |
| core_calib_rd_i | input | 21 | Calibration value from the core |
| core_cur_time_i | input | 32 | Current seconds count |
| core_cur_tick_i | input | 16 | Current sub-second tick |
| core_alarm_rd_i | input | 32 | Alarm value held by the core |
| sec_evt_i | input | 1 | One-cycle seconds event pulse |
| alarm_evt_i | input | 1 | One-cycle alarm match pulse |
| settime_wr_o | output | 1 | Set-time write strobe |
| calib_wr_o | output | 1 | Calibration write strobe |
| alarm_wr_o | output | 1 | Alarm write strobe |
| settime_data_o | output | 32 | Set-time write data |
| calib_data_o | output | 21 | Calibration write data |
| alarm_data_o | output | 32 | Alarm write data |
| irq_sec_o | output | 1 | Seconds interrupt |
| irq_alarm_o | output | 1 | Alarm interrupt |
| osc_en_o | output | 1 | Oscillator enable |
| batt_en_o | output | 1 | Battery switch-over enable |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same clock cycle as a write-one clear of the same status bit. The bench drives the event input and the status write together on one falling edge, so that both are sampled by the same rising edge. It then reads the status back to confirm the bit survived. The mirror case is also covered: a clear with no event, which must drop the bit. This pairing separates a design where the clear wins from one where the set wins.

// File: rtl/tk_reg_pkg.sv
package tk_reg_pkg;

  localparam int DATA_W  = 32;
  localparam int IRQ_N   = 2;
  localparam int IRQ_SEC = 0;
  localparam int IRQ_ALM = 1;

  localparam int CTRL_BATT_BIT = 31;
  localparam int CTRL_OSC_BIT  = 24;

  localparam logic [7:0] OFS_SET_WR  = 8'h00;
  localparam logic [7:0] OFS_SET_RD  = 8'h04;
  localparam logic [7:0] OFS_CAL_WR  = 8'h08;
  localparam logic [7:0] OFS_CAL_RD  = 8'h0C;
  localparam logic [7:0] OFS_CUR_TM  = 8'h10;
  localparam logic [7:0] OFS_CUR_TK  = 8'h14;
  localparam logic [7:0] OFS_ALARM   = 8'h18;
  localparam logic [7:0] OFS_STS     = 8'h20;
  localparam logic [7:0] OFS_MASK    = 8'h24;
  localparam logic [7:0] OFS_IEN     = 8'h28;
  localparam logic [7:0] OFS_IDIS    = 8'h2C;
  localparam logic [7:0] OFS_CTRL    = 8'h40;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SET_WR,
    SEL_SET_RD,
    SEL_CAL_WR,
    SEL_CAL_RD,
    SEL_CUR_TM,
    SEL_CUR_TK,
    SEL_ALARM,
    SEL_STS,
    SEL_MASK,
    SEL_IEN,
    SEL_IDIS,
    SEL_CTRL
  } reg_sel_e;

endpackage

// File: rtl/tk_addr_dec.sv
module tk_addr_dec
  import tk_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  always_comb begin
    sel_o = SEL_NONE;
    case (addr_i)
      ADDR_W'(OFS_SET_WR): sel_o = SEL_SET_WR;
      ADDR_W'(OFS_SET_RD): sel_o = SEL_SET_RD;
      ADDR_W'(OFS_CAL_WR): sel_o = SEL_CAL_WR;
      ADDR_W'(OFS_CAL_RD): sel_o = SEL_CAL_RD;
      ADDR_W'(OFS_CUR_TM): sel_o = SEL_CUR_TM;
      ADDR_W'(OFS_CUR_TK): sel_o = SEL_CUR_TK;
      ADDR_W'(OFS_ALARM):  sel_o = SEL_ALARM;
      ADDR_W'(OFS_STS):    sel_o = SEL_STS;
      ADDR_W'(OFS_MASK):   sel_o = SEL_MASK;
      ADDR_W'(OFS_IEN):    sel_o = SEL_IEN;
      ADDR_W'(OFS_IDIS):   sel_o = SEL_IDIS;
      ADDR_W'(OFS_CTRL):   sel_o = SEL_CTRL;
      default:             sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/tk_irq_ctrl.sv
module tk_irq_ctrl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] sts_w1c_i,
  input  logic [N-1:0] en_w1_i,
  input  logic [N-1:0] dis_w1_i,
  output logic [N-1:0] sts_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] irq_o
);

  logic [N-1:0] sts_q, sts_d;
  logic [N-1:0] mask_q, mask_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // event set has priority over a write-one clear
    always_comb begin
      sts_d[i] = sts_q[i];
      if (evt_i[i]) begin
        sts_d[i] = 1'b1;
      end else if (sts_w1c_i[i]) begin
        sts_d[i] = 1'b0;
      end
    end

    always_comb begin
      mask_d[i] = mask_q[i];
      if (dis_w1_i[i]) begin
        mask_d[i] = 1'b0;
      end else if (en_w1_i[i]) begin
        mask_d[i] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_q[i]  <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        sts_q[i]  <= sts_d[i];
        mask_q[i] <= mask_d[i];
      end
    end

    // R4 R6
    evt_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> sts_q[i]);

    // R5
    w1c_clears_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_w1c_i[i] && !evt_i[i]) |=> !sts_q[i]);

    // R7
    dis_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_w1_i[i] |=> !mask_q[i]);

    // R7
    en_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_w1_i[i] && !dis_w1_i[i]) |=> mask_q[i]);

    // R5 R7
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_i[i] && !sts_w1c_i[i]) |=> $stable(sts_q[i]));
  end

  assign sts_o  = sts_q;
  assign mask_o = mask_q;
  assign irq_o  = sts_q & mask_q;

endmodule

// File: rtl/tk_ctrl_reg.sv
module tk_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic batt_bit_i,
  input  logic osc_bit_i,
  output logic batt_en_o,
  output logic osc_en_o
);

  logic batt_q, batt_d;
  logic osc_q, osc_d;

  always_comb begin
    batt_d = batt_q;
    osc_d  = osc_q;
    if (wr_i) begin
      batt_d = batt_bit_i;
      osc_d  = osc_bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      batt_q <= 1'b0;
      osc_q  <= 1'b0;
    end else begin
      batt_q <= batt_d;
      osc_q  <= osc_d;
    end
  end

  // R9
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (batt_q == $past(batt_bit_i)) && (osc_q == $past(osc_bit_i)));

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(batt_q) && $stable(osc_q));

  assign batt_en_o = batt_q;
  assign osc_en_o  = osc_q;

endmodule

// File: rtl/tk_core_fwd.sv
module tk_core_fwd #(
  parameter int TIME_W = 32,
  parameter int CAL_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr_i,
  input  logic              cal_wr_i,
  input  logic              alm_wr_i,
  input  logic [TIME_W-1:0] time_data_i,
  input  logic [CAL_W-1:0]  cal_data_i,
  output logic              set_wr_o,
  output logic              cal_wr_o,
  output logic              alm_wr_o,
  output logic [TIME_W-1:0] set_data_o,
  output logic [CAL_W-1:0]  cal_data_o,
  output logic [TIME_W-1:0] alm_data_o
);

  logic              set_stb_q, cal_stb_q, alm_stb_q;
  logic [TIME_W-1:0] set_dat_q, set_dat_d;
  logic [CAL_W-1:0]  cal_dat_q, cal_dat_d;
  logic [TIME_W-1:0] alm_dat_q, alm_dat_d;

  always_comb begin
    set_dat_d = set_dat_q;
    cal_dat_d = cal_dat_q;
    alm_dat_d = alm_dat_q;
    if (set_wr_i) set_dat_d = time_data_i;
    if (cal_wr_i) cal_dat_d = cal_data_i;
    if (alm_wr_i) alm_dat_d = time_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_stb_q <= 1'b0;
      cal_stb_q <= 1'b0;
      alm_stb_q <= 1'b0;
      set_dat_q <= '0;
      cal_dat_q <= '0;
      alm_dat_q <= '0;
    end else begin
      set_stb_q <= set_wr_i;
      cal_stb_q <= cal_wr_i;
      alm_stb_q <= alm_wr_i;
      set_dat_q <= set_dat_d;
      cal_dat_q <= cal_dat_d;
      alm_dat_q <= alm_dat_d;
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_stb_q, cal_stb_q, alm_stb_q}));

  // R2
  set_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr_i |=> set_stb_q && (set_dat_q == $past(time_data_i)));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wr_i && !cal_wr_i && !alm_wr_i) |=> !set_stb_q && !cal_stb_q && !alm_stb_q);

  assign set_wr_o   = set_stb_q;
  assign cal_wr_o   = cal_stb_q;
  assign alm_wr_o   = alm_stb_q;
  assign set_data_o = set_dat_q;
  assign cal_data_o = cal_dat_q;
  assign alm_data_o = alm_dat_q;

endmodule

// File: rtl/tk_rtc_regs.sv
module tk_rtc_regs
  import tk_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TIME_W = 32,
  parameter int CAL_W  = 21,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [TIME_W-1:0] core_settime_rd_i,
  input  logic [CAL_W-1:0]  core_calib_rd_i,
  input  logic [TIME_W-1:0] core_cur_time_i,
  input  logic [TICK_W-1:0] core_cur_tick_i,
  input  logic [TIME_W-1:0] core_alarm_rd_i,
  input  logic              sec_evt_i,
  input  logic              alarm_evt_i,
  output logic              settime_wr_o,
  output logic              calib_wr_o,
  output logic              alarm_wr_o,
  output logic [TIME_W-1:0] settime_data_o,
  output logic [CAL_W-1:0]  calib_data_o,
  output logic [TIME_W-1:0] alarm_data_o,
  output logic              irq_sec_o,
  output logic              irq_alarm_o,
  output logic              osc_en_o,
  output logic              batt_en_o
);

  reg_sel_e          sel;
  logic              wr_acc, rd_acc;
  logic [IRQ_N-1:0]  evt, sts_w1c, en_w1, dis_w1;
  logic [IRQ_N-1:0]  sts, mask, irq;
  logic [DATA_W-1:0] rd_d, rdata_q;

  assign wr_acc = bus_valid_i &&  bus_write_i;
  assign rd_acc = bus_valid_i && !bus_write_i;

  tk_addr_dec #(.ADDR_W(ADDR_W)) i_dec (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  // write-one qualifiers for the interrupt block
  always_comb begin
    evt          = '0;
    evt[IRQ_SEC] = sec_evt_i;
    evt[IRQ_ALM] = alarm_evt_i;
    sts_w1c      = (wr_acc && sel == SEL_STS)  ? bus_wdata_i[IRQ_N-1:0] : '0;
    en_w1        = (wr_acc && sel == SEL_IEN)  ? bus_wdata_i[IRQ_N-1:0] : '0;
    dis_w1       = (wr_acc && sel == SEL_IDIS) ? bus_wdata_i[IRQ_N-1:0] : '0;
  end

  tk_irq_ctrl #(.N(IRQ_N)) i_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .sts_w1c_i (sts_w1c),
    .en_w1_i   (en_w1),
    .dis_w1_i  (dis_w1),
    .sts_o     (sts),
    .mask_o    (mask),
    .irq_o     (irq)
  );

  assign irq_sec_o   = irq[IRQ_SEC];
  assign irq_alarm_o = irq[IRQ_ALM];

  tk_ctrl_reg i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_acc && sel == SEL_CTRL),
    .batt_bit_i (bus_wdata_i[CTRL_BATT_BIT]),
    .osc_bit_i  (bus_wdata_i[CTRL_OSC_BIT]),
    .batt_en_o  (batt_en_o),
    .osc_en_o   (osc_en_o)
  );

  tk_core_fwd #(.TIME_W(TIME_W), .CAL_W(CAL_W)) i_fwd (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_wr_i    (wr_acc && sel == SEL_SET_WR),
    .cal_wr_i    (wr_acc && sel == SEL_CAL_WR),
    .alm_wr_i    (wr_acc && sel == SEL_ALARM),
    .time_data_i (bus_wdata_i[TIME_W-1:0]),
    .cal_data_i  (bus_wdata_i[CAL_W-1:0]),
    .set_wr_o    (settime_wr_o),
    .cal_wr_o    (calib_wr_o),
    .alm_wr_o    (alarm_wr_o),
    .set_data_o  (settime_data_o),
    .cal_data_o  (calib_data_o),
    .alm_data_o  (alarm_data_o)
  );

  // read multiplexer
  always_comb begin
    rd_d = '0;
    case (sel)
      SEL_SET_RD: rd_d = DATA_W'(core_settime_rd_i);
      SEL_CAL_RD: rd_d = DATA_W'(core_calib_rd_i);
      SEL_CUR_TM: rd_d = DATA_W'(core_cur_time_i);
      SEL_CUR_TK: rd_d = DATA_W'(core_cur_tick_i);
      SEL_ALARM:  rd_d = DATA_W'(core_alarm_rd_i);
      SEL_STS:    rd_d = DATA_W'(sts);
      SEL_MASK:   rd_d = DATA_W'(mask);
      SEL_CTRL: begin
        rd_d[CTRL_BATT_BIT] = batt_en_o;
        rd_d[CTRL_OSC_BIT]  = osc_en_o;
      end
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_acc) begin
      rdata_q <= rd_d;
    end
  end

  assign bus_rdata_o = rdata_q;

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && (sel == SEL_NONE || sel == SEL_SET_WR || sel == SEL_CAL_WR ||
                sel == SEL_IEN || sel == SEL_IDIS)) |=> (bus_rdata_o == '0));

  // R10
  ro_write_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (sel == SEL_SET_RD || sel == SEL_CUR_TM || sel == SEL_MASK))
      |=> !settime_wr_o && !calib_wr_o && !alarm_wr_o && $stable(mask));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata_o));

endmodule

// File: tb/test_tk_rtc_regs.sv
module test_tk_rtc_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] c_set = 32'hA5A5_0001;
  logic [20:0] c_cal = 21'h12345;
  logic [31:0] c_time = 32'h0000_1234;
  logic [15:0] c_tick = 16'hBEEF;
  logic [31:0] c_alm = 32'hCAFE_0000;
  logic        sec_evt = 1'b0;
  logic        alm_evt = 1'b0;
  logic        set_wr, cal_wr, alm_wr;
  logic [31:0] set_dat, alm_dat;
  logic [20:0] cal_dat;
  logic        irq_sec, irq_alm, osc_en, batt_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tk_rtc_regs i_tk_rtc_regs (
    .clk               (clk),
    .rst_n             (rst_n),
    .bus_valid_i       (bus_valid),
    .bus_write_i       (bus_write),
    .bus_addr_i        (bus_addr),
    .bus_wdata_i       (bus_wdata),
    .bus_rdata_o       (bus_rdata),
    .core_settime_rd_i (c_set),
    .core_calib_rd_i   (c_cal),
    .core_cur_time_i   (c_time),
    .core_cur_tick_i   (c_tick),
    .core_alarm_rd_i   (c_alm),
    .sec_evt_i         (sec_evt),
    .alarm_evt_i       (alm_evt),
    .settime_wr_o      (set_wr),
    .calib_wr_o        (cal_wr),
    .alarm_wr_o        (alm_wr),
    .settime_data_o    (set_dat),
    .calib_data_o      (cal_dat),
    .alarm_data_o      (alm_dat),
    .irq_sec_o         (irq_sec),
    .irq_alarm_o       (irq_alm),
    .osc_en_o          (osc_en),
    .batt_en_o         (batt_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one write; returns at the falling edge after the capturing edge
  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic s, input logic al);
    @(negedge clk);
    sec_evt = s; alm_evt = al;
    @(negedge clk);
    sec_evt = 1'b0; alm_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 outputs", {28'h0, irq_sec, irq_alm, osc_en, batt_en}, 32'h0);
    check("R1 strobes", {29'h0, set_wr, cal_wr, alm_wr}, 32'h0);
    brd(8'h20, d); check("R1 status", d, 32'h0);
    brd(8'h24, d); check("R1 mask", d, 32'h0);
    brd(8'h40, d); check("R1 ctrl", d, 32'h0);
  endtask

  task automatic t_forward();
    bwr(8'h00, 32'h1234_5679);
    check("R2 settime strobe", {29'h0, set_wr, cal_wr, alm_wr}, 32'h4);
    check("R2 settime data", set_dat, 32'h1234_5679);
    @(negedge clk);
    check("R2 strobe one cycle", {29'h0, set_wr, cal_wr, alm_wr}, 32'h0);
    bwr(8'h08, 32'hFFFF_FFFF);
    check("R2 calib strobe", {29'h0, set_wr, cal_wr, alm_wr}, 32'h2);
    check("R2 calib masked", {11'h0, cal_dat}, 32'h001F_FFFF);
    bwr(8'h18, 32'h0BAD_F00D);
    check("R2 alarm strobe", {29'h0, set_wr, cal_wr, alm_wr}, 32'h1);
    check("R2 alarm data", alm_dat, 32'h0BAD_F00D);
  endtask

  task automatic t_core_read();
    logic [31:0] d;
    brd(8'h04, d); check("R3 settime rd", d, 32'hA5A5_0001);
    brd(8'h0C, d); check("R3 calib rd", d, 32'h0001_2345);
    brd(8'h10, d); check("R3 cur time", d, 32'h0000_1234);
    brd(8'h14, d); check("R3 tick", d, 32'h0000_BEEF);
    brd(8'h18, d); check("R3 alarm rd", d, 32'hCAFE_0000);
    repeat (2) @(negedge clk);
    check("R3 rdata held", bus_rdata, 32'hCAFE_0000);
  endtask

  task automatic t_event_set();
    logic [31:0] d;
    pulse(1'b1, 1'b0);
    brd(8'h20, d); check("R4 sec sets bit0 while masked", d, 32'h1);
    check("R8 masked no irq", {30'h0, irq_sec, irq_alm}, 32'h0);
    pulse(1'b0, 1'b1);
    brd(8'h20, d); check("R4 alarm sets bit1", d, 32'h3);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    bwr(8'h20, 32'h0);
    brd(8'h20, d); check("R5 write zero keeps", d, 32'h3);
    bwr(8'h20, 32'h2);
    brd(8'h20, d); check("R5 clear bit1 only", d, 32'h1);
    bwr(8'h20, 32'h1);
    brd(8'h20, d); check("R5 clear bit0", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(1'b1, 1'b0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
    sec_evt = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; sec_evt = 1'b0;
    brd(8'h20, d); check("R6 set wins over clear", d, 32'h1);
    bwr(8'h20, 32'h1);
    brd(8'h20, d); check("R6 clear alone drops", d, 32'h0);
  endtask

  task automatic t_mask_irq();
    logic [31:0] d;
    bwr(8'h28, 32'h1);
    brd(8'h24, d); check("R7 enable sec", d, 32'h1);
    bwr(8'h28, 32'h2);
    brd(8'h24, d); check("R7 enable alarm keeps sec", d, 32'h3);
    bwr(8'h28, 32'h0);
    brd(8'h24, d); check("R7 zero enable no change", d, 32'h3);
    check("R8 no status no irq", {30'h0, irq_sec, irq_alm}, 32'h0);
    pulse(1'b1, 1'b0);
    check("R8 sec irq", {30'h0, irq_sec, irq_alm}, 32'h2);
    pulse(1'b0, 1'b1);
    check("R8 both irq", {30'h0, irq_sec, irq_alm}, 32'h3);
    bwr(8'h2C, 32'h1);
    brd(8'h24, d); check("R7 disable sec", d, 32'h2);
    check("R8 disabled sec irq low", {30'h0, irq_sec, irq_alm}, 32'h1);
    bwr(8'h20, 32'h2);
    check("R8 clear alarm irq low", {30'h0, irq_sec, irq_alm}, 32'h0);
    bwr(8'h2C, 32'h0);
    brd(8'h24, d); check("R7 zero disable no change", d, 32'h2);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    bwr(8'h40, 32'hFFFF_FFFF);
    check("R9 pins set", {30'h0, batt_en, osc_en}, 32'h3);
    brd(8'h40, d); check("R9 readback", d, 32'h8100_0000);
    bwr(8'h40, 32'h0100_0000);
    check("R9 osc only", {30'h0, batt_en, osc_en}, 32'h1);
    bwr(8'h40, 32'h8000_0000);
    brd(8'h40, d); check("R9 batt only", d, 32'h8000_0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    brd(8'h30, d); check("R10 unmapped read", d, 32'h0);
    brd(8'h41, d); check("R10 unaligned read", d, 32'h0);
    brd(8'h00, d); check("R10 write-only read", d, 32'h0);
    brd(8'h28, d); check("R10 enable offset read", d, 32'h0);
    bwr(8'h24, 32'hFFFF_FFFF);
    check("R10 ro write no strobe", {29'h0, set_wr, cal_wr, alm_wr}, 32'h0);
    brd(8'h24, d); check("R10 mask unchanged", d, 32'h2);
    bwr(8'h10, 32'hFFFF_FFFF);
    check("R10 time write no strobe", {29'h0, set_wr, cal_wr, alm_wr}, 32'h0);
    bwr(8'h04, 32'hFFFF_FFFF);
    check("R10 settime rd no strobe", {29'h0, set_wr, cal_wr, alm_wr}, 32'h0);
    bwr(8'h43, 32'hFFFF_FFFF);
    brd(8'h40, d); check("R10 unaligned write ignored", d, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_core_read();
    t_event_set();
    t_w1c();
    t_set_wins();
    t_mask_irq();
    t_ctrl();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule